// File: doc/BRIEF.md
# Reset Release Strap Capture and Asynchronous Input Qualifier

This block watches the processor reset line and the slow asynchronous control inputs of a core. When reset is released it records the clock-ratio strap bus and two single-bit mode straps. It also checks that a warm reset was held long enough before it honours that release. A reset pulse that is too short is reported on a flag, and the previously captured straps stay as they were. The first release after power-on is exempt from the duration rule, because that timing is checked elsewhere.

Each asynchronous input first passes through a synchronizer chain. Level-type inputs are then qualified by a minimum run of asserted samples. Edge-type inputs produce a single-cycle event only when a minimum run of negated samples is followed by a minimum run of asserted samples. The chip's own power-on indication is an asynchronous active-high clear for all state.

All timing below assumes the default parameters: a two-stage synchronizer, a minimum run of 2, and a minimum warm-reset length of 15. "E0" is the first rising clock edge that samples `cpu_rst_i` low after it was high. E1 and E2 are the next two edges, and E-1 is the edge just before E0.

Top module: `rst_strap_qual`

## Requirements
- R1: While `por_i` is high and after it falls, before any release, the outputs hold their clear state: `ratio_o` = RATIO_RST (0), both mode straps 0, `rst_short_o` 0, `lvl_o` 0 and `edge_ev_o` 0.
- R2: On an accepted release, `ratio_o` takes the value `bf_i` had at edge E2 and shows it right after E2.
- R3: On an accepted release, `flush_strap_o` takes the value `flush_i` had at edge E-1, not at E0 or later.
- R4: On an accepted release, `brdyc_strap_o` takes the value `brdyc_i` had at edge E2.
- R5: A warm reset that fewer than 15 rising edges sampled high sets `rst_short_o` to 1 after E2 and leaves all three strap outputs unchanged.
- R6: A warm reset sampled high on 15 or more edges is accepted and clears `rst_short_o` to 0 after E2.
- R7: The first release after `por_i` falls is accepted whatever its length.
- R8: The strap outputs and `rst_short_o` change only right after E2 of a release. Strap input changes at any other time have no effect.
- R9: Bit i of `lvl_o` is 1 right after edge n exactly when `lvl_i[i]` was sampled high at edges n-3 and n-2. A one-edge pulse is never seen.
- R10: Bit i of `edge_ev_o` is 1 for one cycle right after edge n exactly when `edge_i[i]` was sampled low at n-5 and n-4 and high at n-3 and n-2.
- R11: An edge input that is high from power-on does not fire. One that is low for a single edge between high runs does not fire. Each qualified high run fires exactly once however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| por_i | input | 1 | Power-on indication, asynchronous active-high clear |
| cpu_rst_i | input | 1 | Processor reset line, asynchronous, active high |
| bf_i | input | BF_W | Clock-ratio strap pins |
| flush_i | input | 1 | Cache-flush mode strap pin |
| brdyc_i | input | 1 | Ready-input drive-strength mode strap pin |
| lvl_i | input | N_LVL | Asynchronous level-sensitive inputs |
| edge_i | input | N_EDGE | Asynchronous edge-sensitive inputs |
| ratio_o | output | BF_W | Captured clock-ratio strap |
| flush_strap_o | output | 1 | Captured flush mode strap |
| brdyc_strap_o | output | 1 | Captured ready-input mode strap |
| rst_short_o | output | 1 | Last warm reset was shorter than the minimum |
| lvl_o | output | N_LVL | Qualified level inputs |
| edge_ev_o | output | N_EDGE | Single-cycle qualified edge events |

## Verification
Strap capture at a reset release and qualification of edge and level inputs can fall in the same cycle, since both are fed from the same synchronizer timing. The bench keeps random asynchronous traffic running on every qualified input while it drives reset pulses of chosen lengths around the 15-edge boundary. It toggles the strap pins just before and just after the capture window. An edge-accurate history model judges the qualified outputs every cycle, and strap values and the short-reset flag are compared right before and right after E2 of each release.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   typedef enum logic {
      QK_LEVEL = 1'b0,
      QK_EDGE  = 1'b1
   } qual_kind_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         arst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rsq_qual.sv
module rsq_qual
   import rsq_pkg::*;
#(
   parameter qual_kind_e KIND    = QK_LEVEL,
   parameter int         MIN_RUN = 2
) (
   input  logic clk_i,
   input  logic arst_i,
   input  logic s_i,
   output logic q_o
);
   localparam int          CW  = $clog2(MIN_RUN + 1);
   localparam logic [CW-1:0] TOP = CW'(MIN_RUN);

   logic [CW-1:0] hi_q;

   if (KIND == QK_LEVEL) begin : g_lvl
      always_ff @(posedge clk_i or posedge arst_i) begin
         if (arst_i)          hi_q <= '0;
         else if (s_i) begin
            if (hi_q != TOP)  hi_q <= hi_q + 1'b1;
         end else             hi_q <= '0;
      end
      assign q_o = (hi_q == TOP);
   end else begin : g_edge
      logic [CW-1:0] lo_q;
      logic          armed_q;
      logic          ev_q;
      always_ff @(posedge clk_i or posedge arst_i) begin
         if (arst_i) begin
            hi_q    <= '0;
            lo_q    <= '0;
            armed_q <= 1'b0;
            ev_q    <= 1'b0;
         end else begin
            ev_q <= s_i && armed_q && (hi_q == TOP - 1'b1);
            if (s_i) begin
               if (hi_q != TOP) hi_q <= hi_q + 1'b1;
               if (hi_q == '0)  armed_q <= (lo_q == TOP);
               lo_q <= '0;
            end else begin
               if (lo_q != TOP) lo_q <= lo_q + 1'b1;
               hi_q <= '0;
            end
         end
      end
      assign q_o = ev_q;
   end
endmodule

// File: rtl/rsq_strap.sv
module rsq_strap #(
   parameter int             BF_W      = 3,
   parameter int             MIN_WARM  = 15,
   parameter int             FL_DLY    = 3,
   parameter logic [BF_W-1:0] RATIO_RST = '0
) (
   input  logic            clk_i,
   input  logic            arst_i,
   input  logic            rst_s_i,
   input  logic [BF_W-1:0] bf_i,
   input  logic            flush_i,
   input  logic            brdyc_i,
   output logic [BF_W-1:0] ratio_o,
   output logic            flush_o,
   output logic            brdyc_o,
   output logic            short_o
);
   localparam int            CW  = $clog2(MIN_WARM + 1);
   localparam logic [CW-1:0] TOP = CW'(MIN_WARM);

   logic          rst_q;
   logic          cold_q;
   logic [CW-1:0] len_q;
   logic          fl_pipe [FL_DLY];
   logic          release_w;
   logic          accept_w;

   assign release_w = rst_q & ~rst_s_i;
   assign accept_w  = cold_q | (len_q == TOP);

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         rst_q  <= 1'b1;
         cold_q <= 1'b1;
         len_q  <= '0;
         for (int i = 0; i < FL_DLY; i++) fl_pipe[i] <= 1'b0;
      end else begin
         rst_q <= rst_s_i;
         fl_pipe[0] <= flush_i;
         for (int i = 1; i < FL_DLY; i++) fl_pipe[i] <= fl_pipe[i-1];
         if (rst_s_i) begin
            if (len_q != TOP) len_q <= len_q + 1'b1;
         end else begin
            len_q <= '0;
         end
         if (release_w) cold_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         ratio_o <= RATIO_RST;
         flush_o <= 1'b0;
         brdyc_o <= 1'b0;
         short_o <= 1'b0;
      end else if (release_w) begin
         short_o <= ~accept_w;
         if (accept_w) begin
            ratio_o <= bf_i;
            flush_o <= fl_pipe[FL_DLY-1];
            brdyc_o <= brdyc_i;
         end
      end
   end
endmodule

// File: rtl/rst_strap_qual.sv
module rst_strap_qual
   import rsq_pkg::*;
#(
   parameter int              BF_W        = 3,
   parameter int              SYNC_STAGES = 2,
   parameter int              MIN_WARM    = 15,
   parameter int              MIN_PULSE   = 2,
   parameter int              N_LVL       = 4,
   parameter int              N_EDGE      = 4,
   parameter logic [BF_W-1:0] RATIO_RST   = '0
) (
   input  logic              clk_i,
   input  logic              por_i,
   input  logic              cpu_rst_i,
   input  logic [BF_W-1:0]   bf_i,
   input  logic              flush_i,
   input  logic              brdyc_i,
   input  logic [N_LVL-1:0]  lvl_i,
   input  logic [N_EDGE-1:0] edge_i,
   output logic [BF_W-1:0]   ratio_o,
   output logic              flush_strap_o,
   output logic              brdyc_strap_o,
   output logic              rst_short_o,
   output logic [N_LVL-1:0]  lvl_o,
   output logic [N_EDGE-1:0] edge_ev_o
);
   localparam int FL_DLY = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MIN_PULSE < 2) begin : g_bad_pulse
      $error("MIN_PULSE must be at least 2");
   end
   if (MIN_WARM < 1 || BF_W < 1 || N_LVL < 1 || N_EDGE < 1) begin : g_bad_size
      $error("widths and counts must be positive");
   end

   logic              rst_s;
   logic [N_LVL-1:0]  lvl_s;
   logic [N_EDGE-1:0] edge_s;

   rsq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rst (
      .clk_i(clk_i), .arst_i(por_i), .d_i(cpu_rst_i), .q_o(rst_s));

   rsq_sync #(.W(N_LVL), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_lvl (
      .clk_i(clk_i), .arst_i(por_i), .d_i(lvl_i), .q_o(lvl_s));

   rsq_sync #(.W(N_EDGE), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_edge (
      .clk_i(clk_i), .arst_i(por_i), .d_i(edge_i), .q_o(edge_s));

   for (genvar i = 0; i < N_LVL; i++) begin : g_lvl_q
      rsq_qual #(.KIND(QK_LEVEL), .MIN_RUN(MIN_PULSE)) u_q (
         .clk_i(clk_i), .arst_i(por_i), .s_i(lvl_s[i]), .q_o(lvl_o[i]));
   end

   for (genvar i = 0; i < N_EDGE; i++) begin : g_edge_q
      rsq_qual #(.KIND(QK_EDGE), .MIN_RUN(MIN_PULSE)) u_q (
         .clk_i(clk_i), .arst_i(por_i), .s_i(edge_s[i]), .q_o(edge_ev_o[i]));
   end

   rsq_strap #(.BF_W(BF_W), .MIN_WARM(MIN_WARM), .FL_DLY(FL_DLY),
               .RATIO_RST(RATIO_RST)) u_strap (
      .clk_i   (clk_i),
      .arst_i  (por_i),
      .rst_s_i (rst_s),
      .bf_i    (bf_i),
      .flush_i (flush_i),
      .brdyc_i (brdyc_i),
      .ratio_o (ratio_o),
      .flush_o (flush_strap_o),
      .brdyc_o (brdyc_strap_o),
      .short_o (rst_short_o));
endmodule

// File: rtl/rst_strap_qual_chk.sv
module rst_strap_qual_chk #(
   parameter int BF_W     = 3,
   parameter int MIN_WARM = 15,
   parameter int N_LVL    = 4,
   parameter int N_EDGE   = 4
) (
   input logic              clk_i,
   input logic              por_i,
   input logic              rst_s,
   input logic [N_LVL-1:0]  lvl_s,
   input logic [N_LVL-1:0]  lvl_o,
   input logic [N_EDGE-1:0] edge_s,
   input logic [N_EDGE-1:0] edge_ev_o,
   input logic [BF_W-1:0]   ratio_o,
   input logic              flush_strap_o,
   input logic              brdyc_strap_o,
   input logic              rst_short_o
);
   localparam int            CW  = $clog2(MIN_WARM + 1);
   localparam logic [CW-1:0] TOP = CW'(MIN_WARM);

   logic          seen_q;
   logic          first_q;
   logic [CW-1:0] run_q;
   logic          drop_w;
   logic [BF_W+1:0] straps_w;

   assign drop_w   = seen_q & ~rst_s;
   assign straps_w = {ratio_o, flush_strap_o, brdyc_strap_o};

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         seen_q  <= 1'b1;
         first_q <= 1'b1;
         run_q   <= '0;
      end else begin
         seen_q <= rst_s;
         if (drop_w) first_q <= 1'b0;
         if (!rst_s)            run_q <= '0;
         else if (run_q != TOP) run_q <= run_q + 1'b1;
      end
   end

   // R5: short warm reset raises the flag and keeps the straps
   a_r5_short_keeps: assert property (@(posedge clk_i) disable iff (por_i)
      (drop_w && !first_q && run_q != TOP) |=> (rst_short_o && $stable(straps_w)));

   // R6 and R7: long or first release clears the flag
   a_r6_accept_clears: assert property (@(posedge clk_i) disable iff (por_i)
      (drop_w && (first_q || run_q == TOP)) |=> !rst_short_o);

   // R8: nothing moves outside a release
   a_r8_quiet: assert property (@(posedge clk_i) disable iff (por_i)
      !drop_w |=> $stable({straps_w, rst_short_o}));

   // R9: a level output only rises after a high synchronized sample
   a_r9_lvl_rise: assert property (@(posedge clk_i) disable iff (por_i)
      ((lvl_o & ~$past(lvl_o) & ~$past(lvl_s)) == '0));

   // R10: an event needs the synchronized input high just before
   a_r10_ev_src: assert property (@(posedge clk_i) disable iff (por_i)
      ((edge_ev_o & ~$past(edge_s)) == '0));

   // R11: no event lasts two cycles
   a_r11_one_shot: assert property (@(posedge clk_i) disable iff (por_i)
      ((edge_ev_o & $past(edge_ev_o)) == '0));
endmodule

bind rst_strap_qual rst_strap_qual_chk #(
   .BF_W(BF_W), .MIN_WARM(MIN_WARM), .N_LVL(N_LVL), .N_EDGE(N_EDGE)
) u_chk (
   .clk_i        (clk_i),
   .por_i        (por_i),
   .rst_s        (rst_s),
   .lvl_s        (lvl_s),
   .lvl_o        (lvl_o),
   .edge_s       (edge_s),
   .edge_ev_o    (edge_ev_o),
   .ratio_o      (ratio_o),
   .flush_strap_o(flush_strap_o),
   .brdyc_strap_o(brdyc_strap_o),
   .rst_short_o  (rst_short_o)
);

// File: tb/rst_strap_qual_tb.sv
module rst_strap_qual_tb;
   localparam int BF_W   = 3;
   localparam int N_LVL  = 4;
   localparam int N_EDGE = 4;

   logic              clk = 1'b0;
   logic              por;
   logic              cpu_rst;
   logic [BF_W-1:0]   bf;
   logic              flush;
   logic              brdyc;
   logic [N_LVL-1:0]  lvl_i;
   logic [N_EDGE-1:0] edge_i;
   logic [BF_W-1:0]   ratio_o;
   logic              flush_strap_o, brdyc_strap_o, rst_short_o;
   logic [N_LVL-1:0]  lvl_o;
   logic [N_EDGE-1:0] edge_ev_o;

   int n_chk = 0;
   int n_bad = 0;
   int ev_total = 0;
   bit live = 1'b0;
   bit rnd_stop = 1'b0;
   bit done = 1'b0;

   logic [BF_W-1:0]   exp_ratio = '0;
   logic              exp_fl = 1'b0, exp_br = 1'b0, exp_short = 1'b0;
   logic [N_LVL-1:0]  lh [6];
   logic [N_EDGE-1:0] eh [6];
   logic [N_LVL-1:0]  exp_l;
   logic [N_EDGE-1:0] exp_e;

   always #5 clk = ~clk;

   rst_strap_qual u_dut (
      .clk_i(clk), .por_i(por), .cpu_rst_i(cpu_rst), .bf_i(bf),
      .flush_i(flush), .brdyc_i(brdyc), .lvl_i(lvl_i), .edge_i(edge_i),
      .ratio_o(ratio_o), .flush_strap_o(flush_strap_o),
      .brdyc_strap_o(brdyc_strap_o), .rst_short_o(rst_short_o),
      .lvl_o(lvl_o), .edge_ev_o(edge_ev_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // edge-accurate input history (index k = value sampled k edges ago)
   initial begin
      for (int i = 0; i < 6; i++) begin
         lh[i] = '0;
         eh[i] = '1;
      end
   end

   always @(posedge clk) begin
      if (!por) begin
         for (int i = 5; i > 0; i--) begin
            lh[i] <= lh[i-1];
            eh[i] <= eh[i-1];
         end
         lh[0] <= lvl_i;
         eh[0] <= edge_i;
      end
   end

   // R9 and R10: per-cycle comparison against the history model
   always @(negedge clk) begin
      if (!por && live) begin
         exp_l = lh[2] & lh[3];
         exp_e = eh[2] & eh[3] & ~eh[4] & ~eh[5];
         chk(lvl_o == exp_l, "R9 level qualify", int'(lvl_o), int'(exp_l));
         chk(edge_ev_o == exp_e, "R10 edge event", int'(edge_ev_o), int'(exp_e));
         ev_total += $countones(edge_ev_o);
      end
   end

   task automatic check_straps(input string req);
      chk(ratio_o == exp_ratio, req, int'(ratio_o), int'(exp_ratio));
      chk(flush_strap_o == exp_fl, req, int'(flush_strap_o), int'(exp_fl));
      chk(brdyc_strap_o == exp_br, req, int'(brdyc_strap_o), int'(exp_br));
      chk(rst_short_o == exp_short, req, int'(rst_short_o), int'(exp_short));
   endtask

   task automatic rst_pulse(input int n, input logic [BF_W-1:0] bt,
                            input logic ft, input logic rt, input bit cold);
      bit acc;
      acc = cold || (n >= 15);
      @(negedge clk);
      cpu_rst = 1'b1; flush = ~ft; bf = ~bt; brdyc = ~rt;
      repeat (n - 1) @(negedge clk);
      flush = ft;
      @(negedge clk);
      cpu_rst = 1'b0; flush = ~ft;
      @(negedge clk);
      @(negedge clk);
      check_straps("R8 before capture edge");
      bf = bt; brdyc = rt;
      @(negedge clk);
      bf = ~bt; brdyc = ~rt;
      if (acc) begin
         exp_ratio = bt; exp_fl = ft; exp_br = rt; exp_short = 1'b0;
      end else begin
         exp_short = 1'b1;
      end
      if (!acc)
         check_straps("R5 short reset");
      else if (cold)
         check_straps("R7 first release");
      else begin
         chk(ratio_o == exp_ratio, "R2 ratio capture", int'(ratio_o), int'(exp_ratio));
         chk(flush_strap_o == exp_fl, "R3 flush capture", int'(flush_strap_o), int'(exp_fl));
         chk(brdyc_strap_o == exp_br, "R4 brdyc capture", int'(brdyc_strap_o), int'(exp_br));
         chk(rst_short_o == 1'b0, "R6 long reset", int'(rst_short_o), 0);
      end
   endtask

   task automatic gap(input int g);
      for (int i = 0; i < g; i++) begin
         @(negedge clk);
         bf = BF_W'($urandom); flush = 1'($urandom); brdyc = 1'($urandom);
      end
      @(negedge clk);
      check_straps("R8 idle stability");
   endtask

   // strap and reset sequence
   initial begin
      void'($urandom(32'd7341));
      por = 1'b1; cpu_rst = 1'b1; bf = '1; flush = 1'b1; brdyc = 1'b1;
      repeat (3) @(negedge clk);
      check_straps("R1 clear during power-on");
      chk(lvl_o == '0, "R1 level clear", int'(lvl_o), 0);
      chk(edge_ev_o == '0, "R1 event clear", int'(edge_ev_o), 0);
      por = 1'b0; live = 1'b1;
      @(negedge clk);
      check_straps("R1 clear after power-on");
      rst_pulse(5, 3'b101, 1'b1, 1'b1, 1'b1);
      gap(8);
      rst_pulse(14, 3'b010, 1'b0, 1'b0, 1'b0);
      gap(6);
      rst_pulse(15, 3'b110, 1'b0, 1'b1, 1'b0);
      gap(6);
      rst_pulse(3, 3'b001, 1'b1, 1'b0, 1'b0);
      gap(5);
      rst_pulse(40, 3'b011, 1'b1, 1'b0, 1'b0);
      gap(7);
      rst_pulse(1, 3'b100, 1'b0, 1'b1, 1'b0);
      gap(4);
      for (int k = 0; k < 14; k++) begin
         rst_pulse(1 + int'($urandom % 30), BF_W'($urandom),
                   1'($urandom), 1'($urandom), 1'b0);
         gap(3 + int'($urandom % 10));
      end
      rnd_stop = 1'b1;
      repeat (10) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   // asynchronous input traffic: directed corners, then random
   initial begin
      int base;
      lvl_i = '0; edge_i = '1;
      wait (!por);
      @(negedge clk);
      lvl_i = '1;
      @(negedge clk);
      lvl_i = '0;
      #1 base = ev_total;
      repeat (20) @(negedge clk);
      #1 chk(ev_total == base, "R11 high from power-on", ev_total - base, 0);
      edge_i = '0;
      @(negedge clk);
      edge_i = '1;
      repeat (6) @(negedge clk);
      #1 chk(ev_total == base, "R11 one-edge gap", ev_total - base, 0);
      edge_i = '0; lvl_i = '1;
      repeat (3) @(negedge clk);
      edge_i = '1; lvl_i = '0;
      repeat (8) @(negedge clk);
      #1 chk(ev_total - base == N_EDGE, "R11 one event per run",
             ev_total - base, N_EDGE);
      while (!rnd_stop) begin
         @(negedge clk);
         for (int b = 0; b < N_LVL; b++)
            if ($urandom % 3 == 0) lvl_i[b] = ~lvl_i[b];
         for (int b = 0; b < N_EDGE; b++)
            if ($urandom % 3 == 0) edge_i[b] = ~edge_i[b];
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule